// File: doc/BRIEF.md
# Scoreboard Hazard Control Unit

This block is the central hazard tracker for a single-issue pipeline in which instructions finish out of order. Decoded instructions arrive one at a time, each with an operation class, a destination register and up to two tracked source registers. The block assigns each instruction to a free execution unit of its class. It follows the instruction through operand read, execution and result write, and it tells the datapath when each of those steps may happen. There are five units by default: one integer/load unit, a parameterised number of multipliers (two by default), one adder and one divider.

All hazards are resolved by the table, with no result bypassing. A structural hazard or a pending write to the same destination holds issue. Operand read is granted only once every source it needs has been written (RAW). A finished unit may not write back while some other unit still has to read the old value of the same register (WAR). Two tables hold the state. Each unit has a status entry with its phase, its destination, its sources, the unit producing each source and a ready flag for each source. Each register has an entry naming the unit that will write it.

Top module: `sbc_hazard_ctl`

## Requirements
- R1: After a synchronous reset, every unit is idle and no read or write grant is raised.
- R2: An instruction is held (`iss_stall` high, `iss_unit` zero) when every unit of its class is busy. Class codes are 0 integer/load, 1 multiply, 2 add and 3 divide. Unit bit positions are 0 integer, 1 first multiplier, 2 second multiplier, 3 adder and 4 divider.
- R3: An instruction is held while any active instruction will write its destination register. It is accepted in the cycle after that write is granted.
- R4: A held instruction changes no state: no unit becomes busy in the cycle after a stall.
- R5: An accepted instruction is shown one-hot on `iss_unit`. A multiply goes to the lowest-numbered free multiplier.
- R6: A unit is granted operand read, at the earliest in the cycle after it issues, only when no source it uses is still awaited from another unit. A waiting source becomes ready in the cycle after its producer's write grant.
- R7: Read grants for different units may be raised in the same cycle, and each instruction is granted read exactly once.
- R8: `exe_done` for a unit in execution leads to a write grant in the next cycle when there is no WAR conflict. `exe_done` for a unit that has not yet read its operands is ignored.
- R9: A write grant is withheld while another unit that has not yet read its operands names the writer's destination as a used source. It is granted in the cycle after that read.
- R10: A unit granted write is free in the next cycle, not in the same one. An instruction for it stalls in the write cycle and issues in the following one.
- R11: A source whose producer is granted write in the issue cycle counts as ready at once.
- R12: All units eligible to write in one cycle are granted together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| iss_valid | input | 1 | A decoded instruction is offered |
| iss_class | input | 2 | Operation class (0 int/load, 1 mul, 2 add, 3 div) |
| iss_dst | input | log2(NUM_REGS) | Destination register |
| iss_src_a | input | log2(NUM_REGS) | First source register |
| iss_use_a | input | 1 | First source is a tracked register |
| iss_src_b | input | log2(NUM_REGS) | Second source register |
| iss_use_b | input | 1 | Second source is a tracked register |
| iss_stall | output | 1 | Offered instruction cannot issue this cycle |
| iss_unit | output | NUM_MUL+3 | One-hot unit receiving the instruction |
| rd_grant | output | NUM_MUL+3 | Per-unit permission to read operands |
| exe_done | input | NUM_MUL+3 | Per-unit end-of-execution pulse |
| wr_grant | output | NUM_MUL+3 | Per-unit permission to write the result |
| unit_busy | output | NUM_MUL+3 | Per-unit occupancy |

## Verification
The properties assume that the execution units behave: a unit raises `exe_done` only after its read grant, and it does not hold the pulse past the cycle in which it finished. They also assume that an offered instruction which stalls may be withdrawn or held freely, since no state moves on a stall. The stimulus pulses `exe_done` for one cycle, and only for units whose read was granted at least a cycle earlier. The one exception is a deliberate pulse to a unit that is still waiting to read, to show that it is ignored. Instructions are driven one cycle at a time, so every expected grant can be placed on an exact cycle.

// File: rtl/sbc_pkg.sv
package sbc_pkg;

   typedef enum logic [1:0] {
      CLS_INT = 2'd0,
      CLS_MUL = 2'd1,
      CLS_ADD = 2'd2,
      CLS_DIV = 2'd3
   } op_class_e;

   typedef enum logic [1:0] {
      PH_IDLE,
      PH_WAIT_RD,
      PH_EXEC,
      PH_DONE
   } phase_e;

   // unit numbering: 0 integer, 1..num_mul multipliers, then adder, then divider
   function automatic op_class_e unit_class(input int unsigned idx, input int unsigned num_mul);
      if (idx == 0)
         return CLS_INT;
      else if (idx <= num_mul)
         return CLS_MUL;
      else if (idx == num_mul + 1)
         return CLS_ADD;
      else
         return CLS_DIV;
   endfunction

endpackage

// File: rtl/sbc_unit_pick.sv
module sbc_unit_pick
   import sbc_pkg::*;
#(
   parameter int NUM_MUL = 2,
   parameter int NU      = NUM_MUL + 3
) (
   input  op_class_e         want,
   input  logic [NU-1:0]     busy,
   output logic              found,
   output logic [NU-1:0]     pick_oh
);

   logic [NU-1:0] cand;

   for (genvar u = 0; u < NU; u++) begin : g_cand
      localparam op_class_e UC = unit_class(u, NUM_MUL);
      assign cand[u] = (want == UC) && !busy[u];
   end

   // lowest set bit wins
   assign pick_oh = cand & (~cand + NU'(1));
   assign found   = |cand;

endmodule

// File: rtl/sbc_reg_table.sv
module sbc_reg_table #(
   parameter int NUM_REGS = 32,
   parameter int NU       = 5,
   parameter int REG_W    = 5,
   parameter int UID_W    = 3
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              set_en,
   input  logic [REG_W-1:0]  set_reg,
   input  logic [UID_W-1:0]  set_uid,
   input  logic [NU-1:0]     wr_all,
   input  logic [REG_W-1:0]  look_a,
   input  logic [REG_W-1:0]  look_b,
   input  logic [REG_W-1:0]  look_d,
   output logic              hit_a,
   output logic [UID_W-1:0]  own_a,
   output logic              hit_b,
   output logic [UID_W-1:0]  own_b,
   output logic              hit_d
);

   localparam int NP = 1 << UID_W;

   logic [NP-1:0]    wr_pad;
   logic             pend  [NUM_REGS];
   logic [UID_W-1:0] owner [NUM_REGS];

   assign wr_pad = NP'(wr_all);

   for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
      always_ff @(posedge clk) begin
         if (rst) begin
            pend[r]  <= 1'b0;
            owner[r] <= '0;
         end else if (set_en && set_reg == REG_W'(r)) begin
            pend[r]  <= 1'b1;
            owner[r] <= set_uid;
         end else if (pend[r] && wr_pad[owner[r]]) begin
            pend[r]  <= 1'b0;
         end
      end
   end

   assign hit_a = pend[look_a];
   assign own_a = owner[look_a];
   assign hit_b = pend[look_b];
   assign own_b = owner[look_b];
   assign hit_d = pend[look_d];

endmodule

// File: rtl/sbc_unit_slot.sv
module sbc_unit_slot
   import sbc_pkg::*;
#(
   parameter int NU    = 5,
   parameter int REG_W = 5,
   parameter int UID_W = 3
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              issue_en,
   input  logic [REG_W-1:0]  dst_in,
   input  logic [REG_W-1:0]  src_a_in,
   input  logic              use_a_in,
   input  logic              pend_a_in,
   input  logic [UID_W-1:0]  prod_a_in,
   input  logic [REG_W-1:0]  src_b_in,
   input  logic              use_b_in,
   input  logic              pend_b_in,
   input  logic [UID_W-1:0]  prod_b_in,
   input  logic [NU-1:0]     wr_all,
   input  logic              done_in,
   input  logic              war_hold,
   output logic              busy,
   output logic [REG_W-1:0]  dst_q,
   output logic [REG_W-1:0]  src_a_q,
   output logic [REG_W-1:0]  src_b_q,
   output logic              watch_a,
   output logic              watch_b,
   output logic              rd_go,
   output logic              wr_go
);

   localparam int NP = 1 << UID_W;

   phase_e           phase;
   logic             use_a, use_b;
   logic             wait_a, wait_b;
   logic [UID_W-1:0] prod_a, prod_b;
   logic             rdy_a, rdy_b;
   logic [NP-1:0]    wr_pad;

   assign wr_pad  = NP'(wr_all);
   assign busy    = (phase != PH_IDLE);
   assign rd_go   = (phase == PH_WAIT_RD) && rdy_a && rdy_b;
   assign wr_go   = (phase == PH_DONE) && !war_hold;
   assign watch_a = use_a && rdy_a;
   assign watch_b = use_b && rdy_b;

   always_ff @(posedge clk) begin
      if (rst) begin
         phase   <= PH_IDLE;
         use_a   <= 1'b0;
         use_b   <= 1'b0;
         wait_a  <= 1'b0;
         wait_b  <= 1'b0;
         prod_a  <= '0;
         prod_b  <= '0;
         rdy_a   <= 1'b0;
         rdy_b   <= 1'b0;
         dst_q   <= '0;
         src_a_q <= '0;
         src_b_q <= '0;
      end else if (issue_en) begin
         phase   <= PH_WAIT_RD;
         dst_q   <= dst_in;
         src_a_q <= src_a_in;
         src_b_q <= src_b_in;
         use_a   <= use_a_in;
         use_b   <= use_b_in;
         wait_a  <= use_a_in && pend_a_in;
         wait_b  <= use_b_in && pend_b_in;
         prod_a  <= prod_a_in;
         prod_b  <= prod_b_in;
         rdy_a   <= !(use_a_in && pend_a_in);
         rdy_b   <= !(use_b_in && pend_b_in);
      end else begin
         unique case (phase)
            PH_WAIT_RD: begin
               if (rd_go) begin
                  rdy_a <= 1'b0;
                  rdy_b <= 1'b0;
                  phase <= PH_EXEC;
               end else begin
                  if (wait_a && wr_pad[prod_a]) begin
                     wait_a <= 1'b0;
                     rdy_a  <= 1'b1;
                  end
                  if (wait_b && wr_pad[prod_b]) begin
                     wait_b <= 1'b0;
                     rdy_b  <= 1'b1;
                  end
               end
            end
            PH_EXEC: if (done_in) phase <= PH_DONE;
            PH_DONE: if (wr_go)   phase <= PH_IDLE;
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/sbc_hazard_ctl.sv
module sbc_hazard_ctl
   import sbc_pkg::*;
#(
   parameter int NUM_REGS = 32,
   parameter int NUM_MUL  = 2
) (
   input  logic                           clk,
   input  logic                           rst,
   input  logic                           iss_valid,
   input  logic [1:0]                     iss_class,
   input  logic [$clog2(NUM_REGS)-1:0]    iss_dst,
   input  logic [$clog2(NUM_REGS)-1:0]    iss_src_a,
   input  logic                           iss_use_a,
   input  logic [$clog2(NUM_REGS)-1:0]    iss_src_b,
   input  logic                           iss_use_b,
   output logic                           iss_stall,
   output logic [NUM_MUL+2:0]             iss_unit,
   output logic [NUM_MUL+2:0]             rd_grant,
   input  logic [NUM_MUL+2:0]             exe_done,
   output logic [NUM_MUL+2:0]             wr_grant,
   output logic [NUM_MUL+2:0]             unit_busy
);

   localparam int NU    = NUM_MUL + 3;
   localparam int REG_W = $clog2(NUM_REGS);
   localparam int UID_W = $clog2(NU);
   localparam int NP    = 1 << UID_W;

   if (NUM_MUL < 1) begin : g_bad_mul
      $error("NUM_MUL must be at least 1");
   end
   if (NUM_REGS < 2 || (1 << REG_W) != NUM_REGS) begin : g_bad_regs
      $error("NUM_REGS must be a power of two of at least 2");
   end

   logic              found;
   logic [NU-1:0]     pick_oh;
   logic [UID_W-1:0]  pick_id;
   logic              fire;
   logic              hit_a, hit_b, hit_d;
   logic [UID_W-1:0]  own_a, own_b;
   logic              pend_a, pend_b;
   logic [NP-1:0]     wr_pad;
   logic [NU-1:0]     war_hold;
   logic [NU-1:0]     watch_a, watch_b;
   logic [REG_W-1:0]  dst_q   [NU];
   logic [REG_W-1:0]  src_a_q [NU];
   logic [REG_W-1:0]  src_b_q [NU];

   // ---------------- issue ----------------
   sbc_unit_pick #(.NUM_MUL(NUM_MUL), .NU(NU)) u_pick (
      .want    (op_class_e'(iss_class)),
      .busy    (unit_busy),
      .found   (found),
      .pick_oh (pick_oh)
   );

   always_comb begin
      pick_id = '0;
      for (int u = 0; u < NU; u++)
         if (pick_oh[u]) pick_id = UID_W'(u);
   end

   assign iss_stall = iss_valid && (!found || hit_d);
   assign fire      = iss_valid && !iss_stall;
   assign iss_unit  = fire ? pick_oh : '0;

   // ---------------- register result table ----------------
   sbc_reg_table #(.NUM_REGS(NUM_REGS), .NU(NU), .REG_W(REG_W), .UID_W(UID_W)) u_regs (
      .clk     (clk),
      .rst     (rst),
      .set_en  (fire),
      .set_reg (iss_dst),
      .set_uid (pick_id),
      .wr_all  (wr_grant),
      .look_a  (iss_src_a),
      .look_b  (iss_src_b),
      .look_d  (iss_dst),
      .hit_a   (hit_a),
      .own_a   (own_a),
      .hit_b   (hit_b),
      .own_b   (own_b),
      .hit_d   (hit_d)
   );

   // a producer writing back in this very cycle no longer blocks the source
   assign wr_pad = NP'(wr_grant);
   assign pend_a = hit_a && !wr_pad[own_a];
   assign pend_b = hit_b && !wr_pad[own_b];

   // ---------------- per-unit status ----------------
   for (genvar u = 0; u < NU; u++) begin : g_unit
      sbc_unit_slot #(.NU(NU), .REG_W(REG_W), .UID_W(UID_W)) u_slot (
         .clk       (clk),
         .rst       (rst),
         .issue_en  (iss_unit[u]),
         .dst_in    (iss_dst),
         .src_a_in  (iss_src_a),
         .use_a_in  (iss_use_a),
         .pend_a_in (pend_a),
         .prod_a_in (own_a),
         .src_b_in  (iss_src_b),
         .use_b_in  (iss_use_b),
         .pend_b_in (pend_b),
         .prod_b_in (own_b),
         .wr_all    (wr_grant),
         .done_in   (exe_done[u]),
         .war_hold  (war_hold[u]),
         .busy      (unit_busy[u]),
         .dst_q     (dst_q[u]),
         .src_a_q   (src_a_q[u]),
         .src_b_q   (src_b_q[u]),
         .watch_a   (watch_a[u]),
         .watch_b   (watch_b[u]),
         .rd_go     (rd_grant[u]),
         .wr_go     (wr_grant[u])
      );

      // WAR: any other unit still due to read the old value of this destination
      always_comb begin
         war_hold[u] = 1'b0;
         for (int v = 0; v < NU; v++) begin
            if (v != u && unit_busy[v] &&
                ((watch_a[v] && src_a_q[v] == dst_q[u]) ||
                 (watch_b[v] && src_b_q[v] == dst_q[u])))
               war_hold[u] = 1'b1;
         end
      end
   end

endmodule

// File: rtl/sbc_hazard_chk.sv
module sbc_hazard_chk #(
   parameter int NU = 5
) (
   input logic          clk,
   input logic          rst,
   input logic          iss_valid,
   input logic          iss_stall,
   input logic [NU-1:0] iss_unit,
   input logic [NU-1:0] rd_grant,
   input logic [NU-1:0] wr_grant,
   input logic [NU-1:0] unit_busy
);

   assert_reset_idle_R1: assert property (@(posedge clk)
      rst |=> (unit_busy == '0));

   assert_issue_free_R2: assert property (@(posedge clk) disable iff (rst)
      (iss_unit & unit_busy) == '0);

   assert_accept_match_R2: assert property (@(posedge clk) disable iff (rst)
      (iss_unit != '0) == (iss_valid && !iss_stall));

   assert_stall_inert_R4: assert property (@(posedge clk) disable iff (rst)
      (iss_valid && iss_stall) |=> ((unit_busy & ~$past(unit_busy)) == '0));

   assert_issue_onehot_R5: assert property (@(posedge clk) disable iff (rst)
      $onehot0(iss_unit));

   assert_read_busy_R6: assert property (@(posedge clk) disable iff (rst)
      (rd_grant & ~unit_busy) == '0);

   assert_read_once_R7: assert property (@(posedge clk) disable iff (rst)
      (|rd_grant) |=> ((rd_grant & $past(rd_grant)) == '0));

   assert_read_write_apart_R8: assert property (@(posedge clk) disable iff (rst)
      (rd_grant & wr_grant) == '0);

   assert_write_frees_R10: assert property (@(posedge clk) disable iff (rst)
      (|wr_grant) |=> ((unit_busy & $past(wr_grant)) == '0));

endmodule

bind sbc_hazard_ctl sbc_hazard_chk #(.NU(NUM_MUL + 3)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .iss_valid (iss_valid),
   .iss_stall (iss_stall),
   .iss_unit  (iss_unit),
   .rd_grant  (rd_grant),
   .wr_grant  (wr_grant),
   .unit_busy (unit_busy)
);

// File: tb/sim_sbc_hazard_ctl.sv
module sim_sbc_hazard_ctl;

   localparam int CLK_PERIOD = 10;
   localparam int S_UNIT = 0, S_STALL = 1, S_RD = 2, S_WR = 3, S_BUSY = 4;
   localparam logic [1:0] C_INT = 2'd0, C_MUL = 2'd1, C_ADD = 2'd2, C_DIV = 2'd3;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       iss_valid = 1'b0;
   logic [1:0] iss_class = '0;
   logic [4:0] iss_dst = '0, iss_src_a = '0, iss_src_b = '0;
   logic       iss_use_a = 1'b0, iss_use_b = 1'b0;
   logic [4:0] exe_done = '0;
   logic       iss_stall;
   logic [4:0] iss_unit, rd_grant, wr_grant, unit_busy;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit finished = 1'b0;

   int         q_cyc [$];
   int         q_sig [$];
   logic [4:0] q_val [$];
   string      q_req [$];

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(posedge clk) cyc <= rst ? 0 : cyc + 1;

   sbc_hazard_ctl u0 (
      .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_class(iss_class),
      .iss_dst(iss_dst), .iss_src_a(iss_src_a), .iss_use_a(iss_use_a),
      .iss_src_b(iss_src_b), .iss_use_b(iss_use_b), .iss_stall(iss_stall),
      .iss_unit(iss_unit), .rd_grant(rd_grant), .exe_done(exe_done),
      .wr_grant(wr_grant), .unit_busy(unit_busy)
   );

   function automatic logic [4:0] sample(input int s);
      case (s)
         S_UNIT:  return iss_unit;
         S_STALL: return {4'b0, iss_stall};
         S_RD:    return rd_grant;
         S_WR:    return wr_grant;
         default: return unit_busy;
      endcase
   endfunction

   // driver side: queue an expected output value for a given cycle
   task automatic expect_at(input int c, input int s, input logic [4:0] v, input string r);
      q_cyc.push_back(c);
      q_sig.push_back(s);
      q_val.push_back(v);
      q_req.push_back(r);
   endtask

   // monitor side: compare every expectation due in this cycle
   always @(negedge clk) begin
      if (!rst) begin
         for (int i = q_cyc.size() - 1; i >= 0; i--) begin
            if (q_cyc[i] == cyc) begin
               checks++;
               if (sample(q_sig[i]) !== q_val[i]) begin
                  errors++;
                  $display("FAIL %s cycle %0d signal %0d: actual %b expected %b",
                           q_req[i], cyc, q_sig[i], sample(q_sig[i]), q_val[i]);
               end
               q_cyc.delete(i);
               q_sig.delete(i);
               q_val.delete(i);
               q_req.delete(i);
            end
         end
      end
   end

   task automatic step();
      @(posedge clk);
      #1;
      iss_valid = 1'b0;
      exe_done  = '0;
   endtask

   task automatic present(input logic [1:0] cls, input int d, input int sa, input logic ua,
                          input int sb, input logic ub);
      iss_valid = 1'b1;
      iss_class = cls;
      iss_dst   = 5'(d);
      iss_src_a = 5'(sa);
      iss_use_a = ua;
      iss_src_b = 5'(sb);
      iss_use_b = ub;
   endtask

   task automatic finish_run();
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      int b;
      repeat (3) step();
      rst = 1'b0;
      // R1: reset state
      expect_at(cyc, S_BUSY, 5'b00000, "R1");
      expect_at(cyc, S_RD, 5'b00000, "R1");
      expect_at(cyc, S_WR, 5'b00000, "R1");

      // ---- scenario A: RAW chain, structural stalls, simultaneous writes ----
      step(); b = cyc;
      present(C_INT, 6, 0, 0, 0, 0);
      expect_at(b, S_UNIT, 5'b00001, "R5");
      expect_at(b+1, S_RD, 5'b00001, "R6");
      step();
      present(C_ADD, 8, 6, 1, 2, 1);
      expect_at(b+1, S_UNIT, 5'b01000, "R5");
      step();
      exe_done = 5'b00001;
      present(C_MUL, 0, 8, 1, 4, 1);
      expect_at(b+2, S_UNIT, 5'b00010, "R5");
      expect_at(b+2, S_RD, 5'b00000, "R6");
      expect_at(b+3, S_WR, 5'b00001, "R8");
      step();
      present(C_MUL, 10, 4, 1, 4, 1);
      expect_at(b+3, S_UNIT, 5'b00100, "R5");
      expect_at(b+3, S_RD, 5'b00000, "R6");
      step();
      present(C_MUL, 12, 1, 1, 1, 1);
      expect_at(b+4, S_STALL, 5'b00001, "R2");
      expect_at(b+4, S_UNIT, 5'b00000, "R2");
      expect_at(b+4, S_RD, 5'b01100, "R7");
      expect_at(b+4, S_BUSY, 5'b01110, "R10");
      expect_at(b+5, S_BUSY, 5'b01110, "R4");
      step();
      exe_done = 5'b01000;
      step();
      present(C_ADD, 14, 1, 1, 1, 1);
      expect_at(b+6, S_WR, 5'b01000, "R8");
      expect_at(b+6, S_STALL, 5'b00001, "R10");
      step();
      present(C_ADD, 20, 1, 1, 3, 1);
      expect_at(b+7, S_UNIT, 5'b01000, "R10");
      expect_at(b+7, S_RD, 5'b00010, "R6");
      step();
      exe_done = 5'b01110;   // adder is still waiting to read: its pulse is ignored (R8)
      expect_at(b+8, S_RD, 5'b01000, "R6");
      expect_at(b+9, S_WR, 5'b00110, "R12");
      expect_at(b+10, S_WR, 5'b00000, "R8");
      expect_at(b+10, S_BUSY, 5'b01000, "R8");
      step();
      step();
      exe_done = 5'b01000;
      expect_at(b+11, S_WR, 5'b01000, "R8");
      expect_at(b+12, S_BUSY, 5'b00000, "R10");
      repeat (3) step();

      // ---- scenario B: WAR hold, WAW stall, same-cycle producer write ----
      b = cyc;
      present(C_MUL, 4, 1, 1, 1, 1);
      expect_at(b, S_UNIT, 5'b00010, "R5");
      step();
      present(C_DIV, 2, 4, 1, 6, 1);
      expect_at(b+1, S_UNIT, 5'b10000, "R5");
      expect_at(b+1, S_RD, 5'b00010, "R6");
      step();
      present(C_ADD, 6, 1, 1, 3, 1);
      expect_at(b+2, S_UNIT, 5'b01000, "R5");
      expect_at(b+2, S_RD, 5'b00000, "R6");
      expect_at(b+3, S_RD, 5'b01000, "R6");
      step();
      step();
      exe_done = 5'b01000;
      step();
      present(C_INT, 6, 0, 0, 0, 0);
      expect_at(b+5, S_STALL, 5'b00001, "R3");
      expect_at(b+5, S_WR, 5'b00000, "R9");
      step();
      exe_done = 5'b00010;
      expect_at(b+6, S_WR, 5'b00000, "R9");
      step();
      present(C_MUL, 8, 4, 1, 1, 1);
      expect_at(b+7, S_WR, 5'b00010, "R8");
      expect_at(b+7, S_UNIT, 5'b00100, "R5");
      expect_at(b+8, S_RD, 5'b10100, "R11");
      expect_at(b+8, S_WR, 5'b00000, "R9");
      step();
      step();
      present(C_INT, 6, 0, 0, 0, 0);
      expect_at(b+9, S_WR, 5'b01000, "R9");
      expect_at(b+9, S_STALL, 5'b00001, "R3");
      step();
      present(C_INT, 6, 0, 0, 0, 0);
      expect_at(b+10, S_UNIT, 5'b00001, "R3");
      step();
      exe_done = 5'b10100;
      expect_at(b+12, S_WR, 5'b10100, "R12");
      repeat (4) step();

      for (int i = 0; i < q_cyc.size(); i++) begin
         checks++;
         errors++;
         $display("FAIL %s cycle %0d signal %0d: actual never sampled expected %b",
                  q_req[i], q_cyc[i], q_sig[i], q_val[i]);
      end
      finish_run();
   end

   initial begin
      #(CLK_PERIOD * 5000);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual hung expected completion");
         finish_run();
      end
   end

endmodule